// File: doc/BRIEF.md
# Lockable Video Register Write Port

This block is the host-facing register port of a video display processor. The host programs the video register file through an 8-bit control port, one byte at a time. The first byte of a pair is a data value. The second byte carries the target register number, and its top bit marks the pair as a register write. A phase flag tracks which byte of the pair comes next. A status read returns the flag to the data phase, so the host can always resynchronise.

A single `locked` input selects between an enhanced mode and a compatibility mode. In enhanced mode every register in the file can be reached. In compatibility mode the register number folds into a small window. When the wide-text mode bit is set, out-of-window writes are dropped instead of folded. This protects the low registers from software written for a wider register set. While the port is locked, the text name-table base is also presented on a coarser alignment.

A write of a set restore flag to a dedicated register reloads the whole file with its power-on contents. The register contents, the wide-text mode bit and the effective name-table base leave the block as plain outputs, and video generation consumes them.

Top module: `vdp_regport`

## Requirements
- R1: After reset every register holds its default value and the port expects a data byte. The default is `DEF_VAL` (0x04) for register `DEF_IDX` (30) and 0x00 for every other register.
- R2: The first control byte is held as data. If the next byte has bit 7 = 1, the held data is written to the register whose number is given by bits 5:0 of that byte. Bit 6 has no effect. The written value is visible from the following clock cycle.
- R3: If the second byte has bit 7 = 0, no register is written, and the next byte is again taken as data.
- R4: A status read (`stat_rd` = 1) returns the port to the data phase. A control byte presented in the same cycle as a status read is ignored.
- R5: While `locked` = 1 and the wide-text bit is clear, the register number is reduced to its low three bits, so the write lands in registers 0 to 7.
- R6: While `locked` = 1 and the wide-text bit (register 0, bit 2) is set, a write whose register number is above 7 changes no register. Numbers 0 to 7 are still written.
- R7: `name_base` equals register 2 bits 3:0 while unlocked. While locked it equals register 2 bits 3:2 followed by 00.
- R8: `wide_mode` equals register 0 bit 2.
- R9: A write to register 50 whose data has bit 0 = 1 reloads every register, register 50 included, with its R1 default. A write to register 50 with bit 0 = 0 stores the data like any other write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control byte strobe |
| ctl_byte | input | 8 | Control byte |
| stat_rd | input | 1 | Status read, resets the byte phase |
| locked | input | 1 | 1 = compatibility restrictions apply |
| regs_flat | output | NUM_REGS*8 | Register file, register i at bits [8i+7:8i] |
| wide_mode | output | 1 | Wide-text mode bit |
| name_base | output | 4 | Effective text name-table base |

## Verification
The bench builds the block with its default parameters. These are 64 registers, a locked window of 8, the restore register at 50 and the nonzero default at register 30. With these values, registers far above the window can be written while unlocked. A locked write to register 50 therefore folds into register 2 rather than triggering a restore. A restore is also visible as the return of register 30 to 0x04. Random pair sequences toggle the lock, the wide-text bit and status reads. This drives the folding and dropping paths from many register states.

// File: rtl/vdp_regport_pkg.sv
package vdp_regport_pkg;
  localparam int BYTE_W = 8;

  function automatic logic [BYTE_W-1:0] reg_default(int idx, int def_idx, logic [BYTE_W-1:0] def_val);
    return (idx == def_idx) ? def_val : '0;
  endfunction

  function automatic logic [3:0] eff_name_base(logic [3:0] raw, logic lk);
    return lk ? {raw[3:2], 2'b00} : raw;
  endfunction
endpackage

// File: rtl/ctl_byte_seq.sv
module ctl_byte_seq
  import vdp_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [BYTE_W-1:0] ctl_byte,
  input  logic              stat_rd,
  output logic              phase_q,
  output logic [BYTE_W-1:0] data_q,
  output logic              pair_done
);
  logic take;
  assign take      = ctl_we && !stat_rd;
  assign pair_done = take && phase_q && ctl_byte[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      data_q  <= '0;
    end else if (stat_rd) begin
      phase_q <= 1'b0;
    end else if (take) begin
      phase_q <= !phase_q;
      if (!phase_q) data_q <= ctl_byte;
    end
  end
endmodule

// File: rtl/reg_target_dec.sv
module reg_target_dec
  import vdp_regport_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int LOCK_WIN = 8,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int WIN_W   = $clog2(LOCK_WIN)
) (
  input  logic              pair_done,
  input  logic [BYTE_W-1:0] ctl_byte,
  input  logic              locked,
  input  logic              wide,
  output logic              wr_fire,
  output logic              wr_drop,
  output logic [IDX_W-1:0]  wr_idx
);
  logic [IDX_W-1:0] raw;
  logic             above;
  assign raw   = ctl_byte[IDX_W-1:0];
  assign above = (raw >= IDX_W'(LOCK_WIN));

  always_comb begin
    wr_drop = pair_done && locked && wide && above;
    wr_fire = pair_done && !wr_drop;
    if (locked) wr_idx = {{(IDX_W-WIN_W){1'b0}}, raw[WIN_W-1:0]};
    else        wr_idx = raw;
  end
endmodule

// File: rtl/vreg_bank.sv
module vreg_bank
  import vdp_regport_pkg::*;
#(
  parameter int          NUM_REGS    = 64,
  parameter int          RESTORE_REG = 50,
  parameter int          RESTORE_BIT = 0,
  parameter int          DEF_IDX     = 30,
  parameter logic [7:0]  DEF_VAL     = 8'h04,
  localparam int         IDX_W       = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_fire,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic                       restore_fire,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  assign restore_fire = wr_fire && (wr_idx == IDX_W'(RESTORE_REG)) && wr_data[RESTORE_BIT];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= reg_default(i, DEF_IDX, DEF_VAL);
      else if (restore_fire)                     q <= reg_default(i, DEF_IDX, DEF_VAL);
      else if (wr_fire && wr_idx == IDX_W'(i))   q <= wr_data;
    end
    assign regs_flat[i*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/vdp_regport.sv
module vdp_regport
  import vdp_regport_pkg::*;
#(
  parameter int         NUM_REGS    = 64,
  parameter int         LOCK_WIN    = 8,
  parameter int         WIDE_REG    = 0,
  parameter int         WIDE_BIT    = 2,
  parameter int         NAME_REG    = 2,
  parameter int         RESTORE_REG = 50,
  parameter int         RESTORE_BIT = 0,
  parameter int         DEF_IDX     = 30,
  parameter logic [7:0] DEF_VAL     = 8'h04,
  localparam int        IDX_W       = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_we,
  input  logic [7:0]                 ctl_byte,
  input  logic                       stat_rd,
  input  logic                       locked,
  output logic [NUM_REGS*8-1:0]      regs_flat,
  output logic                       wide_mode,
  output logic [3:0]                 name_base
);
  logic             phase_q;
  logic [7:0]       data_q;
  logic             pair_done;
  logic             wr_fire;
  logic             wr_drop;
  logic [IDX_W-1:0] wr_idx;
  logic             restore_fire;

  ctl_byte_seq seq_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_byte(ctl_byte),
    .stat_rd(stat_rd), .phase_q(phase_q), .data_q(data_q), .pair_done(pair_done)
  );

  reg_target_dec #(.NUM_REGS(NUM_REGS), .LOCK_WIN(LOCK_WIN)) dec_i (
    .pair_done(pair_done), .ctl_byte(ctl_byte), .locked(locked), .wide(wide_mode),
    .wr_fire(wr_fire), .wr_drop(wr_drop), .wr_idx(wr_idx)
  );

  vreg_bank #(
    .NUM_REGS(NUM_REGS), .RESTORE_REG(RESTORE_REG), .RESTORE_BIT(RESTORE_BIT),
    .DEF_IDX(DEF_IDX), .DEF_VAL(DEF_VAL)
  ) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_idx(wr_idx), .wr_data(data_q),
    .restore_fire(restore_fire), .regs_flat(regs_flat)
  );

  assign wide_mode = regs_flat[WIDE_REG*BYTE_W + WIDE_BIT];
  assign name_base = eff_name_base(regs_flat[NAME_REG*BYTE_W +: 4], locked);
endmodule

// File: rtl/vdp_regport_chk.sv
module vdp_regport_chk
  import vdp_regport_pkg::*;
#(
  parameter int         NUM_REGS = 64,
  parameter int         LOCK_WIN = 8,
  parameter int         DEF_IDX  = 30,
  parameter logic [7:0] DEF_VAL  = 8'h04,
  localparam int        IDX_W    = $clog2(NUM_REGS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  stat_rd,
  input logic                  locked,
  input logic                  phase_q,
  input logic                  wr_fire,
  input logic                  wr_drop,
  input logic [IDX_W-1:0]      wr_idx,
  input logic [7:0]            data_q,
  input logic                  restore_fire,
  input logic [NUM_REGS*8-1:0] regs_flat,
  input logic [3:0]            name_base
);
  logic [NUM_REGS*8-1:0] dflt_flat;
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_d
    assign dflt_flat[i*8 +: 8] = reg_default(i, DEF_IDX, DEF_VAL);
  end

  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !phase_q); // R4
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !restore_fire) |=> regs_flat[$past(wr_idx)*8 +: 8] == $past(data_q)); // R2
  AST_LOCK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_fire) |-> (wr_idx < IDX_W'(LOCK_WIN))); // R5
  AST_WIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> $stable(regs_flat)); // R6
  AST_NAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> name_base[1:0] == 2'b00); // R7
  AST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    restore_fire |=> regs_flat == dflt_flat); // R9
endmodule

bind vdp_regport vdp_regport_chk #(
  .NUM_REGS(NUM_REGS), .LOCK_WIN(LOCK_WIN), .DEF_IDX(DEF_IDX), .DEF_VAL(DEF_VAL)
) chk_i (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .locked(locked), .phase_q(phase_q),
  .wr_fire(wr_fire), .wr_drop(wr_drop), .wr_idx(wr_idx), .data_q(data_q),
  .restore_fire(restore_fire), .regs_flat(regs_flat), .name_base(name_base)
);

// File: tb/vdp_regport_tb_top.sv
module vdp_regport_tb_top;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_byte = '0;
  logic stat_rd = 1'b0;
  logic locked = 1'b0;
  logic [N*8-1:0] regs_flat;
  logic wide_mode;
  logic [3:0] name_base;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] m_reg [N];
  logic       m_phase;
  logic [7:0] m_data;

  always #10 clk = !clk;

  vdp_regport dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_byte(ctl_byte), .stat_rd(stat_rd),
    .locked(locked), .regs_flat(regs_flat), .wide_mode(wide_mode), .name_base(name_base)
  );

  function automatic logic [7:0] dflt(int i);
    return (i == 30) ? 8'h04 : 8'h00;
  endfunction

  function automatic logic [N*8-1:0] model_flat();
    logic [N*8-1:0] v;
    for (int i = 0; i < N; i++) v[i*8 +: 8] = m_reg[i];
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_reg[i] = dflt(i);
    m_phase = 1'b0;
    m_data  = '0;
  endtask

  task automatic model_apply(logic [7:0] b);
    int raw;
    int idx;
    raw = int'(b[5:0]);
    if (locked) begin
      if (m_reg[0][2] && raw > 7) return;
      idx = raw % 8;
    end else idx = raw;
    if (idx == 50 && m_data[0]) model_reset_regs();
    else m_reg[idx] = m_data;
  endtask

  task automatic model_reset_regs();
    for (int i = 0; i < N; i++) m_reg[i] = dflt(i);
  endtask

  task automatic check(string tag, logic [N*8-1:0] act, logic [N*8-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [3:0] nb;
    nb = locked ? {m_reg[2][3:2], 2'b00} : m_reg[2][3:0];
    check({tag, " regs"}, regs_flat, model_flat());
    check({tag, " R8 wide"}, N'(wide_mode), N'(m_reg[0][2]));
    check({tag, " R7 name"}, N'(name_base), N'(nb));
  endtask

  // one cycle, driven at negedge, model updated after the posedge
  task automatic step(logic we, logic [7:0] b, logic rd);
    ctl_we = we; ctl_byte = b; stat_rd = rd;
    @(posedge clk);
    if (rd) m_phase = 1'b0;
    else if (we) begin
      if (!m_phase) begin m_data = b; m_phase = 1'b1; end
      else begin m_phase = 1'b0; if (b[7]) model_apply(b); end
    end
    @(negedge clk);
    ctl_we = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic wr_pair(logic [7:0] d, logic [7:0] sel);
    step(1'b1, d, 1'b0);
    step(1'b1, sel, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    wr_pair(8'h5A, 8'hC0 | 8'd45);            // R2 bit 6 ignored
    check_all("R2 unlocked reg45");
    wr_pair(8'h11, 8'h12);                    // R3 bit7 clear
    check_all("R3 no write");
    wr_pair(8'h33, 8'h81);
    check_all("R3 phase back reg1");

    step(1'b1, 8'h77, 1'b0);                  // R4 status read mid pair
    step(1'b0, 8'h00, 1'b1);
    wr_pair(8'h44, 8'h83);
    check_all("R4 resync reg3");
    step(1'b1, 8'h66, 1'b0);
    step(1'b1, 8'h85, 1'b1);                  // R4 coincident byte ignored
    wr_pair(8'h22, 8'h86);
    check_all("R4 coincident");

    locked = 1'b1;
    wr_pair(8'h9A, 8'h8D);                    // R5 13 -> 5
    check_all("R5 fold");
    locked = 1'b0;
    wr_pair(8'h04, 8'h80);                    // wide on
    locked = 1'b1;
    wr_pair(8'hE1, 8'h8D);                    // R6 dropped
    check_all("R6 drop");
    wr_pair(8'hE2, 8'h85);
    check_all("R6 in window");

    locked = 1'b0;
    wr_pair(8'h0F, 8'h82);
    @(negedge clk);
    check_all("R7 unlocked name");
    locked = 1'b1;
    @(negedge clk);
    check_all("R7 locked name");

    locked = 1'b0;
    wr_pair(8'h02, 8'hB2);                    // R9 bit0 clear stores
    check_all("R9 plain store");
    wr_pair(8'h01, 8'hB2);                    // R9 restore
    check_all("R9 restore");
    locked = 1'b1;
    wr_pair(8'h03, 8'hB2);                    // folds to reg 2
    check_all("R9 locked folds");

    for (int n = 0; n < 1500; n++) begin
      int r;
      logic [7:0] b;
      r = int'($urandom_range(0, 99));
      if (r < 8) locked = !locked;
      b = 8'($urandom);
      if (m_phase && $urandom_range(0, 3) != 0) b[7] = 1'b1;
      if (!m_phase && $urandom_range(0, 9) == 0) b = 8'h01;
      step(r < 90 || r >= 95, b, r >= 90);
      check_all("R2/R5/R6 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule